// File: doc/BRIEF.md
# Packed Register-Default Init Sequencer

This block brings a peripheral's register file to its power-on defaults. After a start pulse it walks a read-only table of packed records, and it issues one register write for each stored value. When the table is exhausted it issues one last write that selects the oscillator mode. That mode is worked out from the configuration inputs. Each write leaves the block as a three-byte frame on a byte stream with a valid/ready handshake. The downstream bus engine turns these frames into bus transfers.

The table is a chain of records. Each record holds a word count, then a starting register address, then that many 16-bit values. The values go to ascending register addresses. A count word of zero marks the end of the chain. The table memory is external and returns a word one clock after its address is presented.

Top module: `regdef_init_seq`

## Requirements
- R1: A record is a nonzero count word N, then a word whose bits 7:0 give the starting register address A, then N data words. The k-th data word (k from 0) is written to register (A+k) mod 256. Records are read from table address 0 upward with no gaps.
- R2: A count word of zero ends the list. No register write from the list follows it.
- R3: Each register write is sent as three bytes, in this order: the 8-bit register address, then data bits 15:8, then data bits 7:0.
- R4: The oscillator mode is force_mode when force_mode is nonzero. Otherwise it is 1 when ref_khz is 24000 or more, and 2 when ref_khz is below 24000.
- R5: After the list, exactly one more write is sent, to register 0x10. Its data is the mode in bits 2:0, osc_buf in bit 3, and zero in all other bits.
- R6: The table is read with one cycle of latency: rom_data is taken to be the word at the rom_addr presented in the previous cycle.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_byte stays unchanged. A byte is consumed only in a cycle where both are high.
- R8: busy is high from the cycle after an accepted start until the last byte is consumed. done pulses high for exactly one cycle, once per run, in the cycle after the final byte is accepted, and busy is low in that same cycle.
- R9: A start pulse while busy is high is ignored. The run in progress continues unchanged and produces no extra frames and no extra done pulse.
- R10: After reset, busy, done and out_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| rom_addr | output | ROM_AW | Table word address |
| rom_data | input | WORD_W | Table word returned one cycle after its address |
| out_byte | output | 8 | Frame byte |
| out_valid | output | 1 | out_byte holds a byte to send |
| out_ready | input | 1 | Downstream accepts the byte |
| ref_khz | input | KHZ_W | Reference clock frequency in kHz |
| force_mode | input | MODE_W | Forced oscillator mode; zero selects automatic mode |
| osc_buf | input | 1 | Oscillator buffer state |

## Verification
The table contents are randomized with a fixed seed: record counts from one to five, arbitrary start addresses and values, and downstream stalls that are randomly on or off. Directed tables cover four cases that separate specific faults. An empty chain shows whether the terminator is honoured. A record that starts at 0xFE shows whether the address wraps. Reference frequencies of 23999 and 24000 kHz, with and without a forced mode, expose a wrong comparison or a wrong priority between the two mode sources. A second start pulse in the middle of a run shows whether the block restarts or sends a duplicate done.

// File: rtl/regdef_init_seq.sv
module regdef_init_seq #(
  parameter int ROM_AW       = 8,
  parameter int WORD_W       = 16,
  parameter int KHZ_W        = 32,
  parameter int MODE_W       = 3,
  parameter int XTAL_KHZ_MIN = 24000,
  parameter logic [7:0] OSC_REG = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [WORD_W-1:0] rom_data,
  output logic [7:0]        out_byte,
  output logic              out_valid,
  input  logic              out_ready,
  input  logic [KHZ_W-1:0]  ref_khz,
  input  logic [MODE_W-1:0] force_mode,
  input  logic              osc_buf
);
  localparam int LAST_BYTE = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_CNT_REQ, S_CNT_GET, S_ADR_REQ, S_ADR_GET, S_VAL_REQ, S_VAL_GET, S_SEND
  } state_t;

  state_t            state;
  logic [ROM_AW-1:0] ptr;
  logic [WORD_W-1:0] cnt, data;
  logic [7:0]        reg_a;
  logic [1:0]        bidx;
  logic              last;
  logic [MODE_W-1:0] mode_sel;
  logic [WORD_W-1:0] osc_word;

  assign mode_sel  = (force_mode != '0) ? force_mode :
                     (ref_khz >= KHZ_W'(XTAL_KHZ_MIN)) ? MODE_W'(1) : MODE_W'(2);
  assign osc_word  = WORD_W'(mode_sel) | (WORD_W'(osc_buf) << 3);
  assign rom_addr  = ptr;
  assign busy      = (state != S_IDLE);
  assign out_valid = (state == S_SEND);
  assign out_byte  = (bidx == 2'd0) ? reg_a :
                     (bidx == 2'd1) ? data[15:8] : data[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ptr   <= '0;
      cnt   <= '0;
      data  <= '0;
      reg_a <= '0;
      bidx  <= '0;
      last  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          ptr   <= '0;
          last  <= 1'b0;
          state <= S_CNT_REQ;
        end
        S_CNT_REQ: state <= S_CNT_GET;
        S_CNT_GET: begin
          if (rom_data == '0) begin
            reg_a <= OSC_REG;
            data  <= osc_word;
            last  <= 1'b1;
            bidx  <= '0;
            state <= S_SEND;
          end else begin
            cnt   <= rom_data;
            ptr   <= ptr + 1'b1;
            state <= S_ADR_REQ;
          end
        end
        S_ADR_REQ: state <= S_ADR_GET;
        S_ADR_GET: begin
          reg_a <= rom_data[7:0];
          ptr   <= ptr + 1'b1;
          state <= S_VAL_REQ;
        end
        S_VAL_REQ: state <= S_VAL_GET;
        S_VAL_GET: begin
          data  <= rom_data;
          ptr   <= ptr + 1'b1;
          bidx  <= '0;
          state <= S_SEND;
        end
        S_SEND: if (out_ready) begin
          if (bidx == 2'(LAST_BYTE)) begin
            bidx <= '0;
            if (last) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              cnt   <= cnt - 1'b1;
              reg_a <= reg_a + 1'b1;
              state <= (cnt == WORD_W'(1)) ? S_CNT_REQ : S_VAL_REQ;
            end
          end else begin
            bidx <= bidx + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/regdef_init_seq_chk.sv
module regdef_init_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [7:0] out_byte,
  input logic       out_valid,
  input logic       out_ready
);
  a_r7_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);
  a_r7_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_byte));
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !(out_valid && out_ready) |=> busy && !done);
  a_r10_valid_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);
endmodule

bind regdef_init_seq regdef_init_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .out_byte(out_byte), .out_valid(out_valid), .out_ready(out_ready)
);

// File: tb/tb_regdef_init_seq.sv
module tb_regdef_init_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        busy, done, out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  rom_addr, out_byte;
  logic [15:0] rom_data;
  logic [31:0] ref_khz = 32'd27000;
  logic [2:0]  force_mode = '0;
  logic        osc_buf = 1'b0;

  always #4 clk = ~clk;

  regdef_init_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .rom_addr(rom_addr), .rom_data(rom_data), .out_byte(out_byte),
    .out_valid(out_valid), .out_ready(out_ready), .ref_khz(ref_khz),
    .force_mode(force_mode), .osc_buf(osc_buf)
  );

  logic [15:0] rom [256];
  always_ff @(posedge clk) rom_data <= rom[rom_addr];

  int n_checks = 0, n_fail = 0, cycles = 0;
  logic [7:0] cap [1024];
  int cap_n = 0, done_n = 0;
  logic [7:0] exp_b [1024];
  int exp_n;
  int stall_pct = 0;
  logic prev_stall = 1'b0;
  logic [7:0] prev_byte = '0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (out_valid && prev_stall)
      check(out_byte == prev_byte, "R7 byte held", out_byte, prev_byte);
    out_ready = ($urandom_range(99) >= stall_pct);
    if (out_valid && out_ready && cap_n < 1024) begin
      cap[cap_n] = out_byte;
      cap_n++;
    end
    prev_stall = out_valid && !out_ready;
    prev_byte  = out_byte;
    if (done) done_n++;
  end

  function automatic int osc_mode();
    if (force_mode != 0) return force_mode;
    return (ref_khz >= 24000) ? 1 : 2;
  endfunction

  task automatic push(input logic [7:0] a, input logic [15:0] d);
    exp_b[exp_n] = a; exp_b[exp_n+1] = d[15:8]; exp_b[exp_n+2] = d[7:0];
    exp_n += 3;
  endtask

  task automatic build_expected();
    int p = 0;
    exp_n = 0;
    while (rom[p] != 0) begin
      int n = rom[p];
      logic [7:0] a = rom[p+1][7:0];
      p += 2;
      for (int k = 0; k < n; k++) begin
        push(a, rom[p]);
        a++;
        p++;
      end
    end
    push(8'h10, 16'(osc_mode()) | (16'(osc_buf) << 3));
  endtask

  task automatic run(input string name, input bit restart);
    int t = 0;
    build_expected();
    cap_n = 0; done_n = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (restart) begin
      repeat (7) @(negedge clk);
      check(busy == 1'b1, "R8 busy during run", busy, 1);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    while (done_n == 0 && t < 5000) begin @(negedge clk); t++; end
    repeat (6) @(negedge clk);
    check(done_n == 1, {"R8 done count ", name}, done_n, 1);
    check(!busy, "R8 idle after done", busy, 0);
    check(cap_n == exp_n, {"R2 byte count ", name}, cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      if (i >= exp_n - 3)
        check(cap[i] == exp_b[i], {"R4 R5 oscillator frame ", name}, cap[i], exp_b[i]);
      else
        check(cap[i] == exp_b[i], {"R1 R3 R6 list frame ", name}, cap[i], exp_b[i]);
    end
    if (restart) check(cap_n == exp_n && done_n == 1, "R9 start while busy", cap_n, exp_n);
  endtask

  task automatic rand_table();
    int p = 0;
    int nrec = $urandom_range(4);
    for (int r = 0; r < nrec; r++) begin
      int n = $urandom_range(5, 1);
      rom[p] = 16'(n);
      rom[p+1] = 16'($urandom_range(255));
      p += 2;
      for (int k = 0; k < n; k++) begin rom[p] = 16'($urandom); p++; end
    end
    rom[p] = 16'h0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) rom[i] = 16'hFFFF;
    rom[0] = 16'h0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !out_valid, "R10 reset state", {busy, done, out_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !out_valid, "R10 idle after reset", {busy, out_valid}, 0);

    ref_khz = 24000; force_mode = 0; osc_buf = 0;
    run("empty list 24000", 0);
    ref_khz = 23999; osc_buf = 1;
    run("empty list 23999", 0);
    force_mode = 3'd5; ref_khz = 30000;
    run("forced mode", 0);

    force_mode = 0; ref_khz = 19200; osc_buf = 0;
    rom[0] = 16'd3; rom[1] = 16'h00FE; rom[2] = 16'hA1B2; rom[3] = 16'hC3D4;
    rom[4] = 16'h0506; rom[5] = 16'h0;
    stall_pct = 40;
    run("address wrap", 0);

    rom[0] = 16'd2; rom[1] = 16'h0031; rom[2] = 16'h1234; rom[3] = 16'h5678;
    rom[4] = 16'd1; rom[5] = 16'h0002; rom[6] = 16'h9ABC; rom[7] = 16'h0;
    run("two records restart", 1);

    for (int it = 0; it < 20; it++) begin
      rand_table();
      force_mode = ($urandom_range(1)) ? 3'($urandom_range(7)) : 3'd0;
      ref_khz = 32'($urandom_range(30000, 18000));
      osc_buf = 1'($urandom_range(1));
      stall_pct = $urandom_range(60);
      run("random", (it % 4) == 1);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule